// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ready-to-Send Flow Control

This block receives asynchronous serial frames on one input line and turns them into bytes for the rest of the chip. The bit rate is set in two stages. A prescaler divides the system clock by 1, 8 or 32. An 8-bit divider then produces a sampling tick at sixteen times the bit rate, so one bit lasts 16 × (divider + 1) prescaled clocks. Each frame can carry an optional parity bit, of odd or even sense, and ends with one or two stop bits.

An active-low ready-to-send output tells the sender when the receiver can take a byte. It is low only while reception is enabled, the receiver is idle and no unread byte is held. It goes high when a start bit is detected and stays high until software reads the buffer. Each finished frame is placed in a 16-bit buffer word together with overrun, framing, parity and error-summary flags. The same event sets a receive-complete flag and a sticky interrupt request. The polarity of the line and the logic sense of the data bits can each be inverted.

Top module: `uart_rx_rts`

## Requirements
- R1: After reset, rts_n is 1, rx_done and irq_req are 0, and rx_word is all zero.
- R2: While rx_en is 1, the receiver is idle and rx_done is 0, rts_n is driven low. While rx_en is 0, rts_n is high from the next cycle on.
- R3: A falling edge on the polarity-corrected line starts a frame, and rts_n is high for the rest of that frame.
- R4: Data bits are taken least significant bit first into rx_word[7:0]. Bits [11:8] of rx_word always read zero.
- R5: When the stop bits of a frame have been sampled, the byte and its flags are loaded into rx_word, and rx_done and irq_req both set. rts_n stays high until a one-cycle pulse on rd_strobe clears rx_done.
- R6: irq_req stays set after a buffer read. It clears only on a pulse of irq_ack or irq_clr.
- R7: When par_en is 1, the parity bit follows the data bits. The sum of the data bits and the parity bit must be even when par_odd is 0 and odd when par_odd is 1. A mismatch sets rx_word[14]. rx_word[15] is the OR of bits 14, 13 and 12.
- R8: If the first stop bit samples low, rx_word[13] (framing error) is set.
- R9: With two_stop set to 1, the frame has two stop bits. Only the first stop bit is checked for framing.
- R10: If a frame completes while rx_done is still 1, the new byte overwrites the buffer and rx_word[12] (overrun) is set.
- R11: presc_sel selects the prescaler: 00 divides by 1, 01 by 8, 10 by 32, and the reserved code 11 acts like 10. One bit time is 16 × (div_val + 1) prescaled clocks.
- R12: line_inv inverts the received line level, including the idle level. data_inv inverts the eight stored data bits. Parity is computed on the bits as they arrive after line correction and before data inversion.
- R13: Each bit is sampled at the middle of its 16 ticks. If the start bit reads high at its midpoint, the frame is discarded: no flag changes and rts_n returns low.
- R14: While par_en is 0, no parity bit is expected and par_odd has no effect on the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| presc_sel | input | 2 | Prescaler select |
| div_val | input | 8 | Bit-rate divider value |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| line_inv | input | 1 | Invert the line polarity |
| data_inv | input | 1 | Invert the stored data bits |
| rxd | input | 1 | Serial data line, asynchronous |
| rd_strobe | input | 1 | One-cycle read of the buffer low byte |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_clr | input | 1 | Software clear of the interrupt request |
| rx_word | output | 16 | Buffer word: data [7:0], overrun [12], framing [13], parity [14], summary [15] |
| rx_done | output | 1 | Receive-complete flag |
| irq_req | output | 1 | Sticky interrupt request |
| rts_n | output | 1 | Active-low ready-to-send |

## Verification
The assertions take three things for granted. The read strobe, the acknowledge and the software clear are single-cycle pulses. The sender's bit time matches the programmed prescaler and divider closely enough that every mid-bit sample falls inside its bit. The framing settings and the polarity bit are changed only while reception is disabled. The stimulus follows these rules: it derives each bit period from the same settings it applies to the block, and it drops rx_en before touching line_inv or the rate. The only departures from the handshake are deliberate. Two bytes are sent without a read in between to provoke an overrun, and a short low pulse is sent to exercise glitch rejection.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int WORD_W  = 16;
  localparam int OVR_BIT = 12;
  localparam int FER_BIT = 13;
  localparam int PER_BIT = 14;
  localparam int SUM_BIT = 15;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_t;

  typedef enum logic [1:0] {
    PS_DIV1 = 2'b00,
    PS_MID  = 2'b01,
    PS_HI   = 2'b10,
    PS_RSVD = 2'b11
  } presc_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick
  import uart_rx_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_MID = 8,
  parameter int PRE_HI  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       presc_sel,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam int PC_W = $clog2(PRE_HI);

  logic [PC_W-1:0]  pc, pc_lim;
  logic [DIV_W-1:0] dc;
  logic             pre_tick;

  always_comb begin
    case (presc_t'(presc_sel))
      PS_DIV1: pc_lim = '0;
      PS_MID:  pc_lim = PC_W'(PRE_MID - 1);
      default: pc_lim = PC_W'(PRE_HI - 1);
    endcase
  end

  assign pre_tick = (pc == pc_lim);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pc <= '0;
      dc <= '0;
    end else begin
      pc <= pre_tick ? '0 : pc + 1'b1;
      if (pre_tick) dc <= (dc == div_val) ? '0 : dc + 1'b1;
    end
  end

  assign tick = en && pre_tick && (dc == div_val);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              rx,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr,
  output logic              ready
);
  localparam int OVS_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);
  localparam logic [BIT_W-1:0] TOP  = BIT_W'(DATA_W - 1);

  rx_state_t        st;
  logic [OVS_W-1:0] tcnt;
  logic [BIT_W-1:0] bcnt;
  logic             rx_d;
  logic             at_mid, at_end;

  assign at_mid = tick && (tcnt == MID);
  assign at_end = tick && (tcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      rx_d <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      rx_d <= rx;
      if (tick && st != S_IDLE) tcnt <= at_end ? '0 : tcnt + 1'b1;
      if (!en) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (rx_d && !rx) begin
            st   <= S_START;
            tcnt <= '0;
          end
          S_START: if (at_mid) begin
            tcnt <= '0;
            bcnt <= '0;
            perr <= 1'b0;
            st   <= rx ? S_IDLE : S_DATA;
          end
          S_DATA: if (at_end) begin
            data <= {rx, data[DATA_W-1:1]};
            bcnt <= bcnt + 1'b1;
            if (bcnt == TOP) st <= par_en ? S_PAR : S_STOP1;
          end
          S_PAR: if (at_end) begin
            perr <= (^data) ^ rx ^ par_odd;
            st   <= S_STOP1;
          end
          S_STOP1: if (at_end) begin
            ferr <= !rx;
            if (two_stop) st <= S_STOP2;
            else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
          S_STOP2: if (at_end) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign ready = en && (st == S_IDLE) && !done;
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int OVS         = 16,
  parameter int PRE_MID     = 8,
  parameter int PRE_HI      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [1:0]        presc_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              line_inv,
  input  logic              data_inv,
  input  logic              rxd,
  input  logic              rd_strobe,
  input  logic              irq_ack,
  input  logic              irq_clr,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_done,
  output logic              irq_req,
  output logic              rts_n
);
  localparam int PAD_W = WORD_W - 4 - DATA_W;

  logic              rx_s, rx_c, tick;
  logic              frm_done, c_perr, c_ferr, c_ready, ovr;
  logic [DATA_W-1:0] c_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
  );

  assign rx_c = rx_s ^ line_inv;

  uart_rx_tick #(.DIV_W(DIV_W), .PRE_MID(PRE_MID), .PRE_HI(PRE_HI)) u_tick (
    .clk(clk), .rst(rst), .en(rx_en), .presc_sel(presc_sel),
    .div_val(div_val), .tick(tick)
  );

  uart_rx_core #(.DATA_W(DATA_W), .OVS(OVS)) u_core (
    .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .rx(rx_c),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .done(frm_done), .data(c_data), .perr(c_perr), .ferr(c_ferr),
    .ready(c_ready)
  );

  assign ovr = rx_done && !rd_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
      rx_done <= 1'b0;
      irq_req <= 1'b0;
      rts_n   <= 1'b1;
    end else begin
      if (frm_done)
        rx_word <= {(ovr | c_ferr | c_perr), c_perr, c_ferr, ovr,
                    {PAD_W{1'b0}}, c_data ^ {DATA_W{data_inv}}};
      if (frm_done)       rx_done <= 1'b1;
      else if (rd_strobe) rx_done <= 1'b0;
      if (frm_done)                irq_req <= 1'b1;
      else if (irq_ack || irq_clr) irq_req <= 1'b0;
      rts_n <= !(c_ready && !rx_done);
    end
  end
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk
  import uart_rx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              rd_strobe,
  input logic              irq_ack,
  input logic              irq_clr,
  input logic              frm_done,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_done,
  input logic              irq_req,
  input logic              rts_n
);
  // R5: an unread byte holds off the sender
  assert_rts_held_R5: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> rts_n);
  // R2: disabled receiver never signals ready
  assert_rts_off_R2: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> rts_n);
  // R5: frame completion raises both flags
  assert_done_flags_R5: assert property (@(posedge clk) disable iff (rst)
    frm_done |=> (rx_done && irq_req));
  // R5: read clears the complete flag
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frm_done) |=> !rx_done);
  // R6: interrupt request is sticky
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack && !irq_clr) |=> irq_req);
  // R10: completion over an unread byte flags overrun
  assert_overrun_R10: assert property (@(posedge clk) disable iff (rst)
    (frm_done && rx_done && !rd_strobe) |=> rx_word[OVR_BIT]);
endmodule

bind uart_rx_rts uart_rx_rts_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rd_strobe(rd_strobe),
  .irq_ack(irq_ack), .irq_clr(irq_clr), .frm_done(frm_done),
  .rx_word(rx_word), .rx_done(rx_done), .irq_req(irq_req), .rts_n(rts_n)
);

// File: tb/sim_uart_rx_rts.sv
module sim_uart_rx_rts;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        rx_en = 0, par_en = 0, par_odd = 0, two_stop = 0;
  logic        line_inv = 0, data_inv = 0, rxd = 1;
  logic        rd_strobe = 0, irq_ack = 0, irq_clr = 0;
  logic [1:0]  presc_sel = 0;
  logic [7:0]  div_val = 0;
  logic [15:0] rx_word;
  logic        rx_done, irq_req, rts_n;

  int n_chk = 0, n_fail = 0;
  int bit_clks = 16;
  bit auto_read = 1, expect_rise = 1;
  logic [15:0] exp_q[$];
  logic pd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_rts u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .presc_sel(presc_sel),
    .div_val(div_val), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .line_inv(line_inv), .data_inv(data_inv),
    .rxd(rxd), .rd_strobe(rd_strobe), .irq_ack(irq_ack),
    .irq_clr(irq_clr), .rx_word(rx_word), .rx_done(rx_done),
    .irq_req(irq_req), .rts_n(rts_n)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [7:0] d, input bit o,
                                     input bit f, input bit p);
    return {(o | f | p), p, f, o, 4'b0000, d};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic lvl);
    rxd = lvl ^ line_inv;
    repeat (bit_clks) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  // driver: pushes the expected word, then serialises the frame
  task automatic send(input logic [7:0] b, input bit bad_par,
                      input bit bad_s1, input bit bad_s2);
    logic p;
    p = (^b) ^ par_odd ^ bad_par;
    if (expect_rise)
      exp_q.push_back(mk(data_inv ? ~b : b, 0, bad_s1, par_en & bad_par));
    drive(0);
    chk(rts_n == 1, "R3 rts_n during frame", rts_n, 1);
    for (int i = 0; i < 8; i++) drive(b[i]);
    if (par_en) drive(p);
    drive(!bad_s1);
    if (two_stop) drive(!bad_s2);
    rxd = 1 ^ line_inv;
    idle(4);
    if (auto_read) begin
      pulse(rd_strobe);
      idle(3);
      chk(rx_done == 0, "R5 rx_done after read", rx_done, 0);
      chk(rts_n == 0, "R5 rts_n after read", rts_n, 0);
    end
  endtask

  // monitor: compares each completed byte against the scoreboard
  always @(negedge clk) begin
    if (!rst && rx_done && !pd) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected byte", rx_word, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rx_word == e, "R4 word", rx_word, e);
        chk(irq_req == 1, "R5 irq_req set", irq_req, 1);
        chk(rts_n == 1, "R5 rts_n held", rts_n, 1);
      end
    end
    pd = rx_done;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(5);
    rst = 0;
    idle(2);
    chk(rts_n == 1 && rx_done == 0 && irq_req == 0, "R1 flags", {rts_n, rx_done, irq_req}, 3'b100);
    chk(rx_word == 0, "R1 word", rx_word, 0);

    rx_en = 1; idle(4);
    chk(rts_n == 0, "R2 rts_n enabled", rts_n, 0);

    // R4 basic bytes
    send(8'hA5, 0, 0, 0);
    send(8'h01, 0, 0, 0);
    send(8'h80, 0, 0, 0);
    chk(irq_req == 1, "R6 irq after read", irq_req, 1);
    pulse(irq_clr); idle(2);
    chk(irq_req == 0, "R6 irq_clr", irq_req, 0);
    send(8'h3C, 0, 0, 0);
    pulse(irq_ack); idle(2);
    chk(irq_req == 0, "R6 irq_ack", irq_req, 0);

    // R7 parity
    rx_en = 0; par_en = 1; par_odd = 0; idle(3); rx_en = 1; idle(3);
    send(8'h5A, 0, 0, 0);
    send(8'h5A, 1, 0, 0);
    rx_en = 0; par_odd = 1; idle(3); rx_en = 1; idle(3);
    send(8'h07, 0, 0, 0);
    send(8'h07, 1, 0, 0);

    // R14 parity off, odd select ignored
    rx_en = 0; par_en = 0; idle(3); rx_en = 1; idle(3);
    send(8'h07, 0, 0, 0);
    chk(rx_word == mk(8'h07, 0, 0, 0), "R14 odd ignored", rx_word, mk(8'h07, 0, 0, 0));

    // R8 framing
    send(8'hE1, 0, 1, 0);
    chk(rx_word[13] && rx_word[15], "R8 framing flag", rx_word, mk(8'hE1, 0, 1, 0));

    // R9 two stop bits
    rx_en = 0; two_stop = 1; idle(3); rx_en = 1; idle(3);
    send(8'h99, 0, 0, 0);
    send(8'h99, 0, 0, 1);
    chk(rx_word[13] == 0, "R9 second stop unchecked", rx_word[13], 0);
    send(8'h66, 0, 1, 0);
    rx_en = 0; two_stop = 0; idle(3); rx_en = 1; idle(3);

    // R10 overrun
    auto_read = 0;
    send(8'h11, 0, 0, 0);
    expect_rise = 0;
    send(8'h22, 0, 0, 0);
    chk(rx_word == mk(8'h22, 1, 0, 0), "R10 overrun word", rx_word, mk(8'h22, 1, 0, 0));
    pulse(rd_strobe); idle(3);
    chk(rx_done == 0 && rts_n == 0, "R10 read after overrun", {rx_done, rts_n}, 0);
    auto_read = 1; expect_rise = 1;

    // R12 inversions
    rx_en = 0; line_inv = 1; data_inv = 1; rxd = 0; idle(6); rx_en = 1; idle(3);
    chk(rts_n == 0, "R12 inverted idle ready", rts_n, 0);
    send(8'hC3, 0, 0, 0);
    rx_en = 0; line_inv = 0; data_inv = 0; rxd = 1; idle(6);

    // R11 prescaler and divider
    presc_sel = 2'b01; div_val = 8'd1; bit_clks = 16 * 2 * 8; rx_en = 1; idle(3);
    send(8'h6D, 0, 0, 0);
    rx_en = 0; presc_sel = 2'b10; div_val = 8'd0; bit_clks = 16 * 32; idle(3); rx_en = 1; idle(3);
    send(8'hB2, 0, 0, 0);
    rx_en = 0; presc_sel = 2'b11; idle(3); rx_en = 1; idle(3);
    send(8'h4E, 0, 0, 0);
    rx_en = 0; presc_sel = 2'b00; bit_clks = 16; idle(3); rx_en = 1; idle(3);

    // R13 glitch rejection
    rxd = 0; idle(4); rxd = 1; idle(40);
    chk(rx_done == 0, "R13 glitch ignored", rx_done, 0);
    chk(rts_n == 0, "R13 rts_n back low", rts_n, 0);
    send(8'h5C, 0, 0, 0);

    idle(5);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule